// File: doc/BRIEF.md
# Dual-Bank Phase Accumulator with Waveform Shaper

This block is the digital core of a direct digital synthesizer. A 28-bit phase accumulator adds a tuning word on every clock, so the output frequency is the tuning word times the clock frequency divided by 2^28. The top 12 bits of the accumulator, plus a 12-bit phase offset, form a phase address. That address drives either a sine shaper built from a computed quarter-wave table or a triangle shaper. The result is a 10-bit offset-binary amplitude code.

Two tuning words and two phase offsets are stored. The active one of each pair is chosen either by an external select pin, sampled on the rising clock edge, or by a bit in the control register. This lets frequency-shift and phase-shift keying run from hardware pins or from register writes. A datapath clear returns the output to midscale and leaves every programmed register untouched. A sleep input parks the amplitude at midscale while the accumulator keeps running. The accumulator MSB is available directly or after a divide-by-two stage.

Top module: `dds_phase_core`

## Requirements
- R1: While `rst_n` is low, every register is zero except the amplitude register: `phase_addr` is 0, `amp` is 512 (midscale) and `msb_out` is 0.
- R2: On each rising clock edge the accumulator adds the active tuning word, modulo 2^28.
- R3: On each edge `phase_addr` loads the accumulator's top 12 bits plus the active phase word, modulo 4096. The accumulator value used is the one from before that edge's update.
- R4: When control bit 0 is 1, bank selection comes from `fsel_pin` and `psel_pin`. These pins are registered on a rising edge and take effect on the next edge. When bit 0 is 0, control bit 1 selects the frequency bank and control bit 2 selects the phase bank. A value of 1 selects bank 1.
- R5: With control bit 3 at 0, `amp` loads a sine code from the previous `phase_addr` a. Let s = a[11], m = a[10] and i = a[9:4]. If m is 1, i becomes 63-i. Let k = 2i+1 and p = k(256-k). Then mag = floor(511·16p / (5·65536 - 4p)). The code is 512-mag when s is 1 and 512+mag otherwise.
- R6: With control bit 3 at 1, `amp` loads a[10:1] when a[11] is 0, and 1023 - a[10:1] when a[11] is 1.
- R7: While `sleep` is high, `amp` loads 512 on each edge, and the accumulator and `phase_addr` keep advancing.
- R8: A cycle with `dp_clear` high loads the accumulator and `phase_addr` with 0, `amp` with 512, and the divider with 0. The tuning, phase and control registers keep their values. `dp_clear` takes precedence over `sleep`.
- R9: With control bit 4 at 0, `msb_out` is accumulator bit 27. With bit 4 at 1, `msb_out` is a toggle that flips on the edge after the one where bit 27 went from 0 to 1.
- R10: A write with `reg_we` high stores `reg_wdata` at address 0 (tuning word 0), 1 (tuning word 1), 2 (phase word 0, bits 11:0), 3 (phase word 1, bits 11:0) or 4 (control, bits 4:0). Addresses 5 to 7 change nothing. The new value is used from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_clear | input | 1 | Synchronous datapath clear; leaves programmed registers intact |
| sleep | input | 1 | Holds amplitude at midscale |
| fsel_pin | input | 1 | External frequency-bank select |
| psel_pin | input | 1 | External phase-bank select |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 28 | Register write data |
| phase_addr | output | 12 | Phase address for the waveform lookup |
| amp | output | 10 | Offset-binary amplitude code |
| msb_out | output | 1 | Accumulator MSB, optionally divided by two |

## Verification
Every cycle, the assertions check these relations: the accumulator step, the offset addition into `phase_addr`, the midscale forcing by clear and by sleep, and the triangle mapping from one phase address to the next amplitude. The shape of the sine table, the sampling delay of the select pins, the retention of programmed words across a clear, and the divide-by-two toggle cannot be shown by a local property. A behavioural model in the bench checks them across scenarios that cover pin and bit selection, wraparound with a near-maximum tuning word, and ignored addresses.

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  parameter int Q_AW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_clear,
  input  logic             sleep,
  input  logic             fsel_pin,
  input  logic             psel_pin,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [ACC_W-1:0] reg_wdata,
  output logic [PH_W-1:0]  phase_addr,
  output logic [AMP_W-1:0] amp,
  output logic             msb_out
);
  localparam int QN   = 1 << Q_AW;
  localparam int HALF = (1 << (AMP_W-1)) - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W-1));

  function automatic longint qval(input int i);
    longint k, p, d;
    k = 2*i + 1;
    p = k * (4*QN - k);
    d = 16 * longint'(QN) * QN;
    return (longint'(HALF) * 16 * p) / (5*d - 4*p);
  endfunction

  logic [ACC_W-1:0] freq_q [2];
  logic [PH_W-1:0]  phs_q  [2];
  logic [4:0]       ctrl_q;
  logic             fpin_q, ppin_q;
  logic [ACC_W-1:0] acc_q;
  logic             prev_msb_q, tgl_q;

  wire              pin_mode = ctrl_q[0];
  wire              f_bank   = pin_mode ? fpin_q : ctrl_q[1];
  wire              p_bank   = pin_mode ? ppin_q : ctrl_q[2];
  wire [ACC_W-1:0]  f_word   = freq_q[f_bank];
  wire [PH_W-1:0]   p_word   = phs_q[p_bank];
  wire              tri_mode = ctrl_q[3];
  wire              div_mode = ctrl_q[4];
  wire              acc_msb  = acc_q[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q[0] <= '0;
      freq_q[1] <= '0;
      phs_q[0]  <= '0;
      phs_q[1]  <= '0;
      ctrl_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: freq_q[0] <= reg_wdata;
        3'd1: freq_q[1] <= reg_wdata;
        3'd2: phs_q[0]  <= reg_wdata[PH_W-1:0];
        3'd3: phs_q[1]  <= reg_wdata[PH_W-1:0];
        3'd4: ctrl_q    <= reg_wdata[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpin_q <= 1'b0;
      ppin_q <= 1'b0;
    end else begin
      fpin_q <= fsel_pin;
      ppin_q <= psel_pin;
    end
  end

  logic [AMP_W-2:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_qtab
    assign qtab[g] = (AMP_W-1)'(qval(g));
  end

  wire              w_sign = phase_addr[PH_W-1];
  wire              w_mir  = phase_addr[PH_W-2];
  wire [Q_AW-1:0]   q_raw  = phase_addr[PH_W-3 -: Q_AW];
  wire [Q_AW-1:0]   q_idx  = w_mir ? ~q_raw : q_raw;
  wire [AMP_W-1:0]  mag    = AMP_W'(qtab[q_idx]);
  wire [AMP_W-1:0]  sine_v = w_sign ? MID - mag : MID + mag;
  wire [AMP_W-1:0]  tri_lo = phase_addr[PH_W-2 -: AMP_W];
  wire [AMP_W-1:0]  tri_v  = w_sign ? ~tri_lo : tri_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      phase_addr <= '0;
      amp        <= MID;
      prev_msb_q <= 1'b0;
      tgl_q      <= 1'b0;
    end else if (dp_clear) begin
      acc_q      <= '0;
      phase_addr <= '0;
      amp        <= MID;
      prev_msb_q <= 1'b0;
      tgl_q      <= 1'b0;
    end else begin
      acc_q      <= acc_q + f_word;
      phase_addr <= acc_q[ACC_W-1 -: PH_W] + p_word;
      amp        <= sleep ? MID : (tri_mode ? tri_v : sine_v);
      prev_msb_q <= acc_msb;
      tgl_q      <= tgl_q ^ (acc_msb & ~prev_msb_q);
    end
  end

  assign msb_out = div_mode ? tgl_q : acc_msb;
endmodule

module dds_phase_core_chk #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dp_clear,
  input logic             sleep,
  input logic             tri_mode,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] step,
  input logic [PH_W-1:0]  pofs,
  input logic [PH_W-1:0]  phase_addr,
  input logic [AMP_W-1:0] amp
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W-1));

  p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dp_clear) |-> acc == ACC_W'($past(acc) + $past(step)));

  p_phase_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dp_clear) |->
      phase_addr == PH_W'($past(acc[ACC_W-1 -: PH_W]) + $past(pofs)));

  p_tri_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mode && !sleep && !dp_clear) |=>
      amp == ($past(phase_addr[PH_W-1]) ? ~$past(phase_addr[PH_W-2 -: AMP_W])
                                        :  $past(phase_addr[PH_W-2 -: AMP_W])));

  p_sleep_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> amp == MID);

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dp_clear |=> (amp == MID && phase_addr == '0 && acc == '0));
endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dp_clear(dp_clear), .sleep(sleep),
  .tri_mode(tri_mode), .acc(acc_q), .step(f_word), .pofs(p_word),
  .phase_addr(phase_addr), .amp(amp)
);

// File: tb/sim_dds_phase_core.sv
`timescale 1ns/1ps
module sim_dds_phase_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dp_clear = 1'b0, sleep = 1'b0, fsel_pin = 1'b0, psel_pin = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [27:0] reg_wdata = '0;
  logic [11:0] phase_addr;
  logic [9:0]  amp;
  logic        msb_out;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  dds_phase_core u0 (
    .clk(clk), .rst_n(rst_n), .dp_clear(dp_clear), .sleep(sleep),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .phase_addr(phase_addr), .amp(amp), .msb_out(msb_out)
  );

  function automatic int qv(int i);
    longint k, p;
    k = 2*i + 1;
    p = k * (256 - k);
    return int'((511 * 16 * p) / (5 * 65536 - 4 * p));
  endfunction

  function automatic int shape(int a, bit tri_on);
    int i, v;
    if (tri_on) begin
      v = (a >> 1) & 1023;
      return ((a >> 11) & 1) ? 1023 - v : v;
    end
    i = (a >> 4) & 63;
    if ((a >> 10) & 1) i = 63 - i;
    return ((a >> 11) & 1) ? 512 - qv(i) : 512 + qv(i);
  endfunction

  int m_fr[2], m_ph[2], m_ctrl, m_acc, m_pa, m_amp, m_tgl, m_prev, m_pf, m_pp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fr = '{0, 0}; m_ph = '{0, 0};
      m_ctrl = 0; m_acc = 0; m_pa = 0; m_amp = 512;
      m_tgl = 0; m_prev = 0; m_pf = 0; m_pp = 0;
    end else begin
      int fb, pb, n_acc, n_pa, n_amp, n_tgl, n_prev, msb;
      fb = (m_ctrl & 1) ? m_pf : (m_ctrl >> 1) & 1;
      pb = (m_ctrl & 1) ? m_pp : (m_ctrl >> 2) & 1;
      msb = (m_acc >> 27) & 1;
      n_acc = (m_acc + m_fr[fb]) & 32'h0FFF_FFFF;
      n_pa = ((m_acc >> 16) + m_ph[pb]) & 12'hFFF;
      n_amp = sleep ? 512 : shape(m_pa, bit'((m_ctrl >> 3) & 1));
      n_tgl = (msb == 1 && m_prev == 0) ? 1 - m_tgl : m_tgl;
      n_prev = msb;
      if (dp_clear) begin
        n_acc = 0; n_pa = 0; n_amp = 512; n_tgl = 0; n_prev = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_fr[0] = int'(reg_wdata);
          3'd1: m_fr[1] = int'(reg_wdata);
          3'd2: m_ph[0] = int'(reg_wdata) & 12'hFFF;
          3'd3: m_ph[1] = int'(reg_wdata) & 12'hFFF;
          3'd4: m_ctrl  = int'(reg_wdata) & 5'h1F;
          default: ;
        endcase
      end
      m_pf = int'(fsel_pin); m_pp = int'(psel_pin);
      m_acc = n_acc; m_pa = n_pa; m_amp = n_amp; m_tgl = n_tgl; m_prev = n_prev;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("phase_addr", int'(phase_addr), m_pa);
      check("amp", int'(amp), m_amp);
      check("msb_out", int'(msb_out), ((m_ctrl >> 4) & 1) ? m_tgl : (m_acc >> 27) & 1);
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 28'(d);
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #20;
    tag = "R1";
    check("reset phase_addr", int'(phase_addr), 0);
    check("reset amp", int'(amp), 512);
    check("reset msb_out", int'(msb_out), 0);
    @(posedge clk); #2 rst_n = 1'b1;

    tag = "R10";
    wr(0, 28'h080_0000);
    wr(1, 28'h012_3457);
    wr(2, 12'h000);
    wr(3, 12'h400);
    wr(4, 0);
    tag = "R5"; run(70);
    tag = "R2"; wr(4, 5'b00010); run(40);
    tag = "R3"; wr(4, 5'b00110); run(30);
    tag = "R4"; wr(4, 5'b00001);
    for (int k = 0; k < 24; k++) begin
      fsel_pin = k[2]; psel_pin = k[1] ^ k[3];
      run(1);
    end
    fsel_pin = 1'b0; psel_pin = 1'b0;
    tag = "R6"; wr(4, 5'b01000); run(70);
    tag = "R7"; sleep = 1'b1; run(10);
    @(negedge clk) check("sleep amp", int'(amp), 512);
    run(1); sleep = 1'b0; run(10);
    tag = "R8"; wr(4, 5'b00010);
    @(posedge clk); #2 dp_clear = 1'b1; sleep = 1'b1;
    @(posedge clk); #2 dp_clear = 1'b0; sleep = 1'b0;
    @(negedge clk);
    check("clear amp", int'(amp), 512);
    check("clear phase_addr", int'(phase_addr), 0);
    run(40);
    tag = "R9"; wr(4, 5'b10000); run(140);
    tag = "R2"; wr(0, 28'hFFF_FFFF); wr(4, 0); run(30);
    wr(0, 28'hFFF_E001); run(50);
    tag = "R10"; wr(5, 28'h000_0001); wr(7, 28'h1F); run(20);
    finish_run();
  end
endmodule